// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR flash. A client hands it a request to program one word, erase a sector, erase a block or erase the whole array. The block drives the chip-enable and write-strobe bus cycles that make up the matching command sequence. It then reads the device status repeatedly until the internal operation finishes, and reports either success or a timeout.

Requests arrive on a valid/ready handshake carrying an operation code, a word address and a data word. A program request produces four bus writes. Each erase request produces six. Completion is found by reading status bits over the data bus; the device has no busy pin in this scheme. A mode input selects between two checks. In the first, bit 7 is compared with the value it will hold once the operation is complete. In the second, bit 6 must read the same value on two reads in a row.

Every setup, strobe, hold and access interval is a parameter counted in clock cycles. Each operation has its own timeout, also counted in clock cycles. The program timeout is derived from a 20 µs bound and the clock frequency.

Top module: `flash_seq`

## Requirements
- R1: After reset, req_ready is 1, done and error are 0, and fl_ce_n, fl_we_n and fl_oe_n are all 1.
- R2: Operation code 0 (program) emits exactly four writes, as address/data pairs: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R3: Operation codes 1 (sector erase) and 2 (block erase) emit six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the request address with 30h (sector) or 50h (block).
- R4: Operation code 3 (chip erase) emits the same first five writes as R3, with 5555h/10h as the sixth write.
- R5: During every write, fl_ce_n is low while fl_we_n is low. fl_addr does not change while fl_we_n is low. fl_dq_oe is 1 when fl_we_n rises. fl_we_n stays low for exactly T_WP clock cycles.
- R6: req_ready is 0 from the accepted request until done or error is pulsed. A request raised during that time starts no bus activity.
- R7: No status read (fl_oe_n low) occurs before the final write of the sequence has completed.
- R8: With poll_mode = 0, the request completes on the first read whose bit 7 equals the expected final value: bit 7 of the programmed data for a program, and 1 for any erase.
- R9: With poll_mode = 1, the request completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R10: If the operation has not completed when a read finishes at or after the operation's timeout, error pulses for one cycle, done stays 0, and the block returns to ready.
- R11: fl_oe_n is never low while fl_we_n is low, and never low while fl_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Word, sector or block address |
| req_data | input | DW | Word to program |
| poll_mode | input | 1 | 0 bit-7 polling, 1 bit-6 toggle check |
| done | output | 1 | One-cycle pulse on success |
| error | output | 1 | One-cycle pulse on timeout |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Data driven to the flash |
| fl_din | input | DW | Data read from the flash |
| fl_dq_oe | output | 1 | Host drives the data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The hardest case to reach from the ports is the toggle check: completion depends on the history of bit 6 across reads, and the device's busy phase shapes that history. The bench models the flash so that bit 6 alternates on each read for a chosen number of reads and then settles to a chosen value. This lets it place the first matching pair at a known read. The bench computes that read index independently of the design and checks the design's count of reads against it. For the timeout case the model stays busy forever, so error arrives only once the program bound expires.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLOCK = 2'd2, OP_CHIP = 2'd3} op_t;
  typedef enum logic [2:0] {S_IDLE, S_WR, S_WRW, S_RD, S_RDW} st_t;
  typedef enum logic [2:0] {B_IDLE, B_SU, B_WP, B_HD, B_RD} bst_t;
  localparam logic [15:0] UNLK_A = 16'h5555;
  localparam logic [15:0] UNLK_B = 16'h2AAA;
endpackage

// File: rtl/flash_seq_bus.sv
module flash_seq_bus #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int T_SU = 2,
  parameter int T_WP = 3,
  parameter int T_HD = 1,
  parameter int T_ACC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          cyc_done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  input  logic [DW-1:0] fl_din,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  import flash_seq_pkg::*;

  localparam int TMAX = (T_SU > T_WP ? T_SU : T_WP) > (T_HD > T_ACC ? T_HD : T_ACC)
                        ? (T_SU > T_WP ? T_SU : T_WP) : (T_HD > T_ACC ? T_HD : T_ACC);
  localparam int CW = $clog2(TMAX + 1);

  bst_t          bst;
  logic [CW-1:0] cnt;
  wire           cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst <= B_IDLE;
      cnt <= '0;
      cyc_done <= 1'b0;
      rdata <= '0;
      fl_addr <= '0;
      fl_dout <= '0;
    end else begin
      cyc_done <= 1'b0;
      case (bst)
        B_IDLE: begin
          if (wr_go) begin
            fl_addr <= addr;
            fl_dout <= wdata;
            cnt <= CW'(T_SU - 1);
            bst <= B_SU;
          end else if (rd_go) begin
            fl_addr <= addr;
            cnt <= CW'(T_ACC - 1);
            bst <= B_RD;
          end
        end
        B_SU: if (cnt_zero) begin cnt <= CW'(T_WP - 1); bst <= B_WP; end else cnt <= cnt - 1'b1;
        B_WP: if (cnt_zero) begin cnt <= CW'(T_HD - 1); bst <= B_HD; end else cnt <= cnt - 1'b1;
        B_HD: if (cnt_zero) begin bst <= B_IDLE; cyc_done <= 1'b1; end else cnt <= cnt - 1'b1;
        B_RD: if (cnt_zero) begin
                rdata <= fl_din;
                bst <= B_IDLE;
                cyc_done <= 1'b1;
              end else cnt <= cnt - 1'b1;
        default: bst <= B_IDLE;
      endcase
    end
  end

  assign fl_ce_n  = (bst == B_IDLE);
  assign fl_we_n  = (bst != B_WP);
  assign fl_oe_n  = (bst != B_RD);
  assign fl_dq_oe = (bst == B_SU) || (bst == B_WP) || (bst == B_HD);

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> !fl_ce_n); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr)); // R5
  AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_oe_n && !fl_we_n)); // R11
  AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> !fl_ce_n); // R11
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  wire           at_max = (cnt == {TW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= '0;
    else if (!at_max) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(at_max) && !$past(start)) |-> at_max); // R10
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int T_SU = 2,
  parameter int T_WP = 3,
  parameter int T_HD = 1,
  parameter int T_ACC = 2,
  parameter int CLK_MHZ = 200,
  parameter int PROG_US = 20,
  parameter int SECT_US = 25000,
  parameter int BLK_US = 25000,
  parameter int CHIP_US = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          poll_mode,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dout,
  input  logic [DW-1:0] fl_din,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  import flash_seq_pkg::*;

  localparam int TO_PROG = PROG_US * CLK_MHZ;
  localparam int TO_SECT = SECT_US * CLK_MHZ;
  localparam int TO_BLK  = BLK_US * CLK_MHZ;
  localparam int TO_CHIP = CHIP_US * CLK_MHZ;
  localparam int TO_M1   = TO_PROG > TO_SECT ? TO_PROG : TO_SECT;
  localparam int TO_M2   = TO_BLK > TO_CHIP ? TO_BLK : TO_CHIP;
  localparam int TO_MAX  = TO_M1 > TO_M2 ? TO_M1 : TO_M2;
  localparam int TW      = $clog2(TO_MAX + 2);

  function automatic logic [2:0] last_idx(op_t op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic logic [AW-1:0] cmd_addr(op_t op, logic [2:0] i, logic [AW-1:0] a);
    if (i == last_idx(op)) return (op == OP_CHIP) ? AW'(UNLK_A) : a;
    return (i == 3'd1 || i == 3'd4) ? AW'(UNLK_B) : AW'(UNLK_A);
  endfunction

  function automatic logic [DW-1:0] cmd_data(op_t op, logic [2:0] i, logic [DW-1:0] d);
    if (i == last_idx(op)) begin
      case (op)
        OP_PROG:  return d;
        OP_SECT:  return DW'(8'h30);
        OP_BLOCK: return DW'(8'h50);
        default:  return DW'(8'h10);
      endcase
    end
    case (i)
      3'd0, 3'd3: return DW'(8'hAA);
      3'd1, 3'd4: return DW'(8'h55);
      default:    return (op == OP_PROG) ? DW'(8'hA0) : DW'(8'h80);
    endcase
  endfunction

  function automatic logic [TW-1:0] op_limit(op_t op);
    case (op)
      OP_PROG:  return TW'(TO_PROG);
      OP_SECT:  return TW'(TO_SECT);
      OP_BLOCK: return TW'(TO_BLK);
      default:  return TW'(TO_CHIP);
    endcase
  endfunction

  st_t           st;
  op_t           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx;
  logic          mode_q, first_rd, prev6;
  logic          bus_done, tmr_exp;
  logic [DW-1:0] bus_rdata;

  wire accept     = (st == S_IDLE) && req_valid;
  wire wr_go      = (st == S_WR);
  wire rd_go      = (st == S_RD);
  wire seq_last   = (st == S_WRW) && bus_done && (idx == last_idx(op_q));
  wire exp7       = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  wire rd_end     = (st == S_RDW) && bus_done;
  wire poll_hit   = mode_q ? (!first_rd && (bus_rdata[6] == prev6)) : (bus_rdata[7] == exp7);
  wire timed_out  = rd_end && !poll_hit && tmr_exp;

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      idx <= '0;
      mode_q <= 1'b0;
      first_rd <= 1'b1;
      prev6 <= 1'b0;
      done <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= 1'b0;
      error <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q <= op_t'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          mode_q <= poll_mode;
          idx <= '0;
          first_rd <= 1'b1;
          st <= S_WR;
        end
        S_WR:  st <= S_WRW;
        S_WRW: if (bus_done) begin
          if (seq_last) st <= S_RD;
          else begin idx <= idx + 1'b1; st <= S_WR; end
        end
        S_RD:  st <= S_RDW;
        S_RDW: if (rd_end) begin
          prev6 <= bus_rdata[6];
          first_rd <= 1'b0;
          if (poll_hit) begin done <= 1'b1; st <= S_IDLE; end
          else if (timed_out) begin error <= 1'b1; st <= S_IDLE; end
          else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  flash_seq_bus #(.AW(AW), .DW(DW), .T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD), .T_ACC(T_ACC)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
    .addr(rd_go ? addr_q : cmd_addr(op_q, idx, addr_q)),
    .wdata(cmd_data(op_q, idx, data_q)),
    .cyc_done(bus_done), .rdata(bus_rdata),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  flash_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(seq_last), .limit(op_limit(op_q)), .expired(tmr_exp)
  );

  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> fl_ce_n); // R6
  AST_READ_AFTER_SEQ: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> (st == S_RDW)); // R7
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && error)); // R10
  AST_END_TO_READY: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> req_ready); // R6
endmodule

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  localparam int AW = 20, DW = 16, T_SU = 2, T_WP = 3, T_HD = 1, T_ACC = 2;
  localparam int TO_PROG_CYC = 20 * 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, poll_mode = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, error, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dout, fl_din;

  always #2.5 clk = ~clk;

  flash_seq #(.AW(AW), .DW(DW), .T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD), .T_ACC(T_ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_mode(poll_mode), .done(done), .error(error),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int tests = 0, fails = 0, cyc = 0;
  int wcount = 0, rcount = 0, m_len = 4, m_busy = 0;
  int tim_err = 0, early_rd = 0, overlap = 0, wl = 0;
  logic [DW-1:0] m_final = '0;
  logic [AW-1:0] a_fall, w_addr [0:7];
  logic [DW-1:0] w_data [0:7];
  logic prev_oe = 1'b1;

  wire busy = (wcount >= m_len) && (rcount < m_busy);
  assign fl_din = busy ? {8'h00, ~m_final[7], rcount[0], 6'h00} : m_final;

  always @(negedge fl_we_n) a_fall = fl_addr;
  always @(posedge fl_we_n) if (fl_ce_n === 1'b0) begin
    if (fl_addr !== a_fall || fl_dq_oe !== 1'b1 || wl != T_WP) tim_err++;
    if (wcount < 8) begin w_addr[wcount] = fl_addr; w_data[wcount] = fl_dout; end
    wcount++;
  end
  always @(negedge clk) begin
    cyc++;
    if (fl_we_n === 1'b0) wl++; else wl = 0;
    if (fl_we_n === 1'b0 && fl_ce_n !== 1'b0) tim_err++;
    if (fl_oe_n === 1'b0 && (fl_we_n === 1'b0 || fl_ce_n !== 1'b0)) overlap++;
    if (fl_oe_n === 1'b0 && wcount < m_len) early_rd++;
    if (prev_oe === 1'b0 && fl_oe_n === 1'b1) rcount++;
    prev_oe = fl_oe_n;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h, expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] e_addr(int op, int i, logic [AW-1:0] a);
    int last = (op == 0) ? 3 : 5;
    if (i == last) return (op == 3) ? AW'(16'h5555) : a;
    if (i == 1 || i == 4) return AW'(16'h2AAA);
    return AW'(16'h5555);
  endfunction

  function automatic logic [DW-1:0] e_data(int op, int i, logic [DW-1:0] d);
    logic [7:0] fin [0:3];
    int last = (op == 0) ? 3 : 5;
    fin[1] = 8'h30; fin[2] = 8'h50; fin[3] = 8'h10; fin[0] = 8'h00;
    if (i == last) return (op == 0) ? d : DW'(fin[op]);
    if (i == 0 || i == 3) return DW'(8'hAA);
    if (i == 1 || i == 4) return DW'(8'h55);
    return (op == 0) ? DW'(8'hA0) : DW'(8'h80);
  endfunction

  function automatic int toggle_reads(int nbusy, logic f6);
    logic prev = 1'b0;
    for (int r = 0; r < 1000; r++) begin
      logic v = (r < nbusy) ? logic'(r % 2) : f6;
      if (r > 0 && v == prev) return r + 1;
      prev = v;
    end
    return -1;
  endfunction

  bit got_done, got_err;
  int ncyc;

  task automatic run_req(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic mode, input int nbusy, input logic [DW-1:0] fin, input bit poke);
    m_len = (op == 0) ? 4 : 6; m_busy = nbusy; m_final = fin;
    wcount = 0; rcount = 0; tim_err = 0; early_rd = 0; overlap = 0;
    got_done = 0; got_err = 0; ncyc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_data = d; poll_mode = mode;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd3;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!done && !error && ncyc < 20000) begin
      @(negedge clk);
      ncyc++;
      if (done) got_done = 1;
      if (error) got_err = 1;
    end
  endtask

  task automatic chk_seq(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    for (int i = 0; i < m_len; i++) begin
      chk(w_addr[i] == e_addr(op, i, a), {req, " write address"}, w_addr[i], e_addr(op, i, a));
      chk(w_data[i] == e_data(op, i, d), {req, " write data"}, w_data[i], e_data(op, i, d));
    end
    chk(wcount == m_len, {req, " write count"}, wcount, m_len);
    chk(tim_err == 0, "R5 strobe timing violations", tim_err, 0);
    chk(early_rd == 0, "R7 read before final write", early_rd, 0);
    chk(overlap == 0, "R11 output-enable overlap", overlap, 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !done && !error, "R1 ready/done/error after reset", {req_ready, done, error}, 3'b100);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle after reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
  endtask

  task automatic t_program_dq7();
    run_req(0, 20'h1_2345, 16'hBEEF, 1'b0, 5, 16'hBEEF, 1'b0);
    chk_seq(0, 20'h1_2345, 16'hBEEF, "R2");
    chk(got_done && !got_err, "R8 program completes", {got_done, got_err}, 2'b10);
    chk(rcount == 6, "R8 bit-7 poll read count", rcount, 6);
    run_req(0, 20'h0_0042, 16'h1234, 1'b0, 3, 16'h1234, 1'b0);
    chk(rcount == 4, "R8 bit-7 poll with low data bit", rcount, 4);
  endtask

  task automatic t_busy_reject();
    run_req(0, 20'h0_0100, 16'h00A5, 1'b0, 40, 16'h00A5, 1'b1);
    chk(wcount == 4, "R6 request while busy ignored", wcount, 4);
    chk(got_done, "R6 busy request run completes", got_done, 1);
    repeat (4) @(negedge clk);
    chk(wcount == 4 && fl_ce_n, "R6 no bus activity after busy request", wcount, 4);
    chk(req_ready, "R6 ready back after done", req_ready, 1);
  endtask

  task automatic t_erases();
    run_req(1, 20'h3_0800, 16'h0000, 1'b0, 7, 16'hFFFF, 1'b0);
    chk_seq(1, 20'h3_0800, 16'h0000, "R3 sector");
    chk(got_done && rcount == 8, "R8 sector erase bit-7 poll", rcount, 8);
    run_req(2, 20'h8_0000, 16'h0000, 1'b0, 2, 16'hFFFF, 1'b0);
    chk_seq(2, 20'h8_0000, 16'h0000, "R3 block");
    chk(got_done && rcount == 3, "R8 block erase bit-7 poll", rcount, 3);
    run_req(3, 20'hF_FFFF, 16'h0000, 1'b0, 4, 16'hFFFF, 1'b0);
    chk_seq(3, 20'hF_FFFF, 16'h0000, "R4 chip");
    chk(got_done && rcount == 5, "R8 chip erase bit-7 poll", rcount, 5);
  endtask

  task automatic t_toggle();
    int exp;
    run_req(0, 20'h0_0007, 16'h0040, 1'b1, 3, 16'h0040, 1'b0);
    exp = toggle_reads(3, 1'b1);
    chk(got_done && rcount == exp, "R9 toggle, final bit 6 high", rcount, exp);
    run_req(1, 20'h0_1000, 16'h0000, 1'b1, 3, 16'hFFBF, 1'b0);
    exp = toggle_reads(3, 1'b0);
    chk(got_done && rcount == exp, "R9 toggle, final bit 6 low", rcount, exp);
    run_req(2, 20'h1_0000, 16'h0000, 1'b1, 0, 16'hFFFF, 1'b0);
    exp = toggle_reads(0, 1'b1);
    chk(got_done && rcount == exp, "R9 toggle, already complete", rcount, exp);
  endtask

  task automatic t_timeout();
    run_req(0, 20'h0_0200, 16'h0080, 1'b0, 1000000, 16'h0080, 1'b0);
    chk(got_err && !got_done, "R10 error on timeout", {got_done, got_err}, 2'b01);
    chk(ncyc >= TO_PROG_CYC && ncyc <= TO_PROG_CYC + 80, "R10 timeout cycle window", ncyc, TO_PROG_CYC);
    @(negedge clk);
    chk(req_ready && fl_ce_n, "R10 back to ready after error", req_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program_dq7();
    t_busy_reject();
    t_erases();
    t_toggle();
    t_timeout();
    finish_run();
  end
endmodule